// File: doc/BRIEF.md
# USB Endpoint Handshake and Halt Control

This block decides which handshake a USB device returns for each transaction and keeps the per-endpoint state that drives that decision. The serial engine presents one decoded transaction per pulse of `tok_valid`. The pulse carries the token kind, the endpoint number and whether the token and data packets were received intact. The block answers one cycle later with no handshake, ACK, NAK or STALL, and updates the endpoint's halt, data toggle and FIFO-ready flags.

A local host CPU steers the block through single-cycle strobes aimed at the endpoint on `host_sel`. The strobes halt an endpoint, clear a halt on the control endpoint, reset an endpoint, mark its FIFO ready, force STALL on the control endpoint, and configure or unconfigure the device. Endpoint 0 is the control endpoint. Two things make it STALL without touching its halt bit: a forced-stall command, and a latch that holds STALL once one has been sent. Both stay in force until a valid setup arrives.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: A low `rst_n` or a high `bus_reset` at a clock edge clears every halt, toggle and FIFO-ready bit, the forced-stall command, the STALL latch, the configured flag and `resp_valid`.
- R2: `resp_valid` is high in exactly the cycle after each cycle in which `tok_valid` was high (outside reset). `resp_code` is then meaningful, encoded as 0 none, 1 ACK, 2 NAK, 3 STALL.
- R3: A transaction with `tok_ok` low, or with the reserved kind 3, gets code 0 and changes no endpoint state. Token kinds are encoded as 0 OUT, 1 IN, 2 SETUP.
- R4: A valid SETUP is answered ACK whatever the halt, forced-stall and FIFO state of the endpoint.
- R5: A valid SETUP sets that endpoint's toggle to 0. On endpoint 0 it also clears the halt bit, the forced-stall command and the STALL latch.
- R6: A valid OUT or IN gets STALL when the endpoint's halt bit is set, or when it targets endpoint 0 while the forced-stall command or the STALL latch is set. STALL takes priority over NAK.
- R7: A valid OUT or IN that is not stalled and whose FIFO-ready bit is clear gets NAK, and no state changes.
- R8: A valid OUT or IN that is neither stalled nor NAKed gets ACK, inverts that endpoint's toggle and clears its FIFO-ready bit.
- R9: Once STALL has been sent on endpoint 0, OUT and IN on endpoint 0 keep getting STALL, even after its halt bit is cleared, until a valid SETUP arrives.
- R10: `host_set_halt` sets the selected endpoint's halt bit. `host_stall_cmd` leaves every halt bit unchanged.
- R11: `host_ep_reset` clears the selected endpoint's halt, toggle and FIFO-ready bits.
- R12: `host_clr_halt` clears the halt bit only when `host_sel` is 0; for any other endpoint it has no effect.
- R13: `host_cfg` sets the configured flag when it is clear. `host_uncfg` clears it when it is set.
- R14: Host strobes take effect after transaction updates made in the same cycle. Within the host strobes the order is reset, then clear-halt, then set-halt, then FIFO-ready. A transaction is decided on the state held before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | USB bus reset seen on the line, synchronous clear |
| tok_valid | input | 1 | One decoded transaction needs a handshake decision |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 reserved |
| tok_ep | input | EPW | Endpoint addressed by the transaction |
| tok_ok | input | 1 | Token and data packets were received intact |
| host_sel | input | EPW | Endpoint addressed by the host strobes |
| host_set_halt | input | 1 | Halt the selected endpoint |
| host_clr_halt | input | 1 | Clear halt, endpoint 0 only |
| host_ep_reset | input | 1 | Reset the selected endpoint |
| host_fifo_set | input | 1 | Mark the selected endpoint's FIFO ready |
| host_stall_cmd | input | 1 | Force STALL on endpoint 0 until next SETUP |
| host_cfg | input | 1 | Move from addressed to configured |
| host_uncfg | input | 1 | Move from configured to addressed |
| resp_valid | output | 1 | Handshake decision valid |
| resp_code | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| ep_halted | output | NUM_EP | Halt status per endpoint |
| ep_toggle | output | NUM_EP | Expected data toggle per endpoint (0 = DATA0) |
| ep_fifo_en | output | NUM_EP | FIFO-ready flag per endpoint |
| dev_configured | output | 1 | Device is in the configured state |

## Verification
A stuck or wrongly cleared halt bit shows on `ep_halted` in the cycle after the strobe. It also shows as a wrong STALL or ACK on the next transaction to that endpoint. The forced-stall command and the STALL latch have no status output, so an error in either appears only in `resp_code`, on the first endpoint 0 OUT or IN after the event. The bench therefore follows every clear-halt and every SETUP with such a transaction. A toggle or FIFO-ready error is visible on the outputs one cycle after the transaction that caused it. The reference model is compared against every output on every clock, so each of these faults is caught within one or two cycles of being exposed.

// File: rtl/usb_hs_pkg.sv
// Shared encodings for the endpoint handshake block.
// Assumes a two-bit token kind and a two-bit handshake code on the ports.
package usb_hs_pkg;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_code_e;

endpackage

// File: rtl/usb_ep_slot.sv
// Per-endpoint state: halt, expected data toggle, FIFO-ready flag.
// Assumes all strobes are already qualified for this endpoint by the top.
// Host strobes override transaction updates made in the same cycle.
module usb_ep_slot #(
    parameter bit IS_CTRL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic setup_hit,
    input  logic ack_hit,
    input  logic host_hit,
    input  logic host_set_halt,
    input  logic host_clr_halt,
    input  logic host_ep_reset,
    input  logic host_fifo_set,
    output logic halted,
    output logic toggle,
    output logic fifo_en
);

    logic clr_ok;
    logic setup_clr;
    logic nxt_halt;
    logic nxt_tog;
    logic nxt_fifo;

    // Only the control endpoint honours clear-halt and setup halt release.
    generate
        if (IS_CTRL) begin : g_ctrl
            assign clr_ok    = host_hit & host_clr_halt;
            assign setup_clr = setup_hit;
        end else begin : g_data
            assign clr_ok    = 1'b0 & host_clr_halt;
            assign setup_clr = 1'b0;
        end
    endgenerate

    // Next halt: setup release, then host reset, clear, set in rising priority.
    always_comb begin
        nxt_halt = halted;
        if (setup_clr)                  nxt_halt = 1'b0;
        if (host_hit && host_ep_reset)  nxt_halt = 1'b0;
        if (clr_ok)                     nxt_halt = 1'b0;
        if (host_hit && host_set_halt)  nxt_halt = 1'b1;
    end

    // Next toggle: setup restarts, ACK flips, host reset restarts.
    always_comb begin
        nxt_tog = toggle;
        if (setup_hit)                  nxt_tog = 1'b0;
        if (ack_hit)                    nxt_tog = ~toggle;
        if (host_hit && host_ep_reset)  nxt_tog = 1'b0;
    end

    // Next FIFO-ready: ACK consumes, host reset clears, host set arms.
    always_comb begin
        nxt_fifo = fifo_en;
        if (ack_hit)                    nxt_fifo = 1'b0;
        if (host_hit && host_ep_reset)  nxt_fifo = 1'b0;
        if (host_hit && host_fifo_set)  nxt_fifo = 1'b1;
    end

    // State registers with synchronous reset and bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            halted  <= 1'b0;
            toggle  <= 1'b0;
            fifo_en <= 1'b0;
        end else begin
            halted  <= nxt_halt;
            toggle  <= nxt_tog;
            fifo_en <= nxt_fifo;
        end
    end

endmodule

// File: rtl/usb_ctrl_stall.sv
// Control-endpoint stall sources kept apart from its halt bit:
// a host forced-stall command and a latch that holds STALL once sent.
// Both are released only by a valid setup on endpoint 0.
module usb_ctrl_stall (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic setup_ep0,
    input  logic stall_sent_ep0,
    input  logic host_stall_cmd,
    output logic stall_force
);

    logic cmd_q;
    logic latch_q;

    // Forced-stall command: host set wins over setup release.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            cmd_q <= 1'b0;
        end else if (host_stall_cmd) begin
            cmd_q <= 1'b1;
        end else if (setup_ep0) begin
            cmd_q <= 1'b0;
        end
    end

    // STALL persistence latch: set on a sent STALL, cleared by setup.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            latch_q <= 1'b0;
        end else if (setup_ep0) begin
            latch_q <= 1'b0;
        end else if (stall_sent_ep0) begin
            latch_q <= 1'b1;
        end
    end

    assign stall_force = cmd_q | latch_q;

endmodule

// File: rtl/usb_hs_decide.sv
// Combinational handshake decision for one transaction.
// Priority: damaged or reserved -> none, setup -> ACK, stall -> STALL,
// FIFO not ready -> NAK, else ACK. Uses state held before this cycle.
module usb_hs_decide
    import usb_hs_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
) (
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              tok_ok,
    input  logic [NUM_EP-1:0] halted,
    input  logic [NUM_EP-1:0] fifo_en,
    input  logic              stall_force,
    output hs_code_e          code,
    output logic              setup_ack,
    output logic              data_ack,
    output logic              stall_sent
);

    logic is_ep0;
    logic ep_halt;
    logic ep_fifo;

    assign is_ep0  = (tok_ep == '0);
    assign ep_halt = halted[tok_ep];
    assign ep_fifo = fifo_en[tok_ep];

    // Priority chain producing the handshake and its side-effect strobes.
    always_comb begin
        code       = HS_NONE;
        setup_ack  = 1'b0;
        data_ack   = 1'b0;
        stall_sent = 1'b0;
        if (tok_valid && tok_ok && tok_kind != TK_RSVD) begin
            if (tok_kind == TK_SETUP) begin
                code      = HS_ACK;
                setup_ack = 1'b1;
            end else if (ep_halt || (is_ep0 && stall_force)) begin
                code       = HS_STALL;
                stall_sent = 1'b1;
            end else if (!ep_fifo) begin
                code = HS_NAK;
            end else begin
                code     = HS_ACK;
                data_ack = 1'b1;
            end
        end
    end

endmodule

// File: rtl/usb_cfg_state.sv
// Addressed / configured device state under host control.
// Assumes the host issues configure and unconfigure as one-cycle strobes.
module usb_cfg_state (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic host_cfg,
    input  logic host_uncfg,
    output logic configured
);

    // Configure only from addressed, unconfigure only from configured.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            configured <= 1'b0;
        end else if (host_cfg && !configured) begin
            configured <= 1'b1;
        end else if (host_uncfg && configured) begin
            configured <= 1'b0;
        end
    end

endmodule

// File: rtl/usb_ep_hs_ctrl.sv
// Top of the endpoint handshake and halt control block.
// Decides the handshake for each decoded transaction, registers it for one
// cycle, and holds halt, toggle and FIFO-ready state for NUM_EP endpoints.
// Assumes endpoint 0 is the control endpoint and at most one transaction
// per cycle.
module usb_ep_hs_ctrl
    import usb_hs_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              tok_ok,
    input  logic [EPW-1:0]    host_sel,
    input  logic              host_set_halt,
    input  logic              host_clr_halt,
    input  logic              host_ep_reset,
    input  logic              host_fifo_set,
    input  logic              host_stall_cmd,
    input  logic              host_cfg,
    input  logic              host_uncfg,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic [NUM_EP-1:0] ep_halted,
    output logic [NUM_EP-1:0] ep_toggle,
    output logic [NUM_EP-1:0] ep_fifo_en,
    output logic              dev_configured
);

    hs_code_e code;
    logic     setup_ack;
    logic     data_ack;
    logic     stall_sent;
    logic     stall_force;
    logic     setup_ep0;
    logic     stall_ep0;

    usb_hs_decide #(.NUM_EP(NUM_EP), .EPW(EPW)) u_decide (
        .tok_valid   (tok_valid),
        .tok_kind    (tok_kind),
        .tok_ep      (tok_ep),
        .tok_ok      (tok_ok),
        .halted      (ep_halted),
        .fifo_en     (ep_fifo_en),
        .stall_force (stall_force),
        .code        (code),
        .setup_ack   (setup_ack),
        .data_ack    (data_ack),
        .stall_sent  (stall_sent)
    );

    assign setup_ep0 = setup_ack  && (tok_ep == '0);
    assign stall_ep0 = stall_sent && (tok_ep == '0);

    usb_ctrl_stall u_ctrl_stall (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_reset      (bus_reset),
        .setup_ep0      (setup_ep0),
        .stall_sent_ep0 (stall_ep0),
        .host_stall_cmd (host_stall_cmd),
        .stall_force    (stall_force)
    );

    // One state slot per endpoint; slot 0 is the control endpoint.
    generate
        for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
            logic tok_here;
            logic host_here;
            assign tok_here  = (tok_ep   == EPW'(i));
            assign host_here = (host_sel == EPW'(i));
            usb_ep_slot #(.IS_CTRL(i == 0)) u_slot (
                .clk           (clk),
                .rst_n         (rst_n),
                .bus_reset     (bus_reset),
                .setup_hit     (setup_ack & tok_here),
                .ack_hit       (data_ack & tok_here),
                .host_hit      (host_here),
                .host_set_halt (host_set_halt),
                .host_clr_halt (host_clr_halt),
                .host_ep_reset (host_ep_reset),
                .host_fifo_set (host_fifo_set),
                .halted        (ep_halted[i]),
                .toggle        (ep_toggle[i]),
                .fifo_en       (ep_fifo_en[i])
            );
        end
    endgenerate

    usb_cfg_state u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .host_cfg   (host_cfg),
        .host_uncfg (host_uncfg),
        .configured (dev_configured)
    );

    // Handshake output register, one cycle after the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) begin
            resp_valid <= 1'b0;
            resp_code  <= HS_NONE;
        end else begin
            resp_valid <= tok_valid;
            resp_code  <= code;
        end
    end

endmodule

// File: rtl/usb_ep_hs_ctrl_chk.sv
// Property checker for usb_ep_hs_ctrl, attached by bind below.
// Observes ports only; assumes the encodings of usb_hs_pkg.
module usb_ep_hs_ctrl_chk #(
    parameter int NUM_EP = 4,
    localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_reset,
    input logic              tok_valid,
    input logic [1:0]        tok_kind,
    input logic              tok_ok,
    input logic [EPW-1:0]    host_sel,
    input logic              host_set_halt,
    input logic              host_clr_halt,
    input logic              host_ep_reset,
    input logic              host_stall_cmd,
    input logic              host_cfg,
    input logic              host_uncfg,
    input logic              resp_valid,
    input logic [1:0]        resp_code,
    input logic [NUM_EP-1:0] ep_halted,
    input logic [NUM_EP-1:0] ep_toggle,
    input logic              dev_configured
);

    // R1: bus reset clears halts, configuration and the response.
    a_r1_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (ep_halted == '0) && !dev_configured && !resp_valid);

    // R2: a response follows each transaction by one cycle.
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !bus_reset) |=> resp_valid);

    // R2: no response without a transaction.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !resp_valid);

    // R3: damaged or reserved transactions get no handshake.
    a_r3_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !bus_reset && (!tok_ok || tok_kind == 2'd3))
        |=> resp_code == 2'd0);

    // R4: valid setup always answered ACK.
    a_r4_setup_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !bus_reset && tok_ok && tok_kind == 2'd2)
        |=> resp_code == 2'd1);

    // R10: the forced-stall command leaves halt bits alone.
    a_r10_cmd_keeps_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stall_cmd && !host_set_halt && !host_clr_halt && !host_ep_reset
         && !tok_valid && !bus_reset) |=> $stable(ep_halted));

    // R11: endpoint reset clears halt and toggle of the selected endpoint.
    a_r11_ep_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ep_reset && !host_set_halt && !bus_reset)
        |=> !ep_halted[$past(host_sel)] && !ep_toggle[$past(host_sel)]);

    // R13: configure from addressed sets the flag.
    a_r13_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cfg && !dev_configured && !bus_reset) |=> dev_configured);

    // R13: unconfigure from configured clears the flag.
    a_r13_uncfg: assert property (@(posedge clk) disable iff (!rst_n)
        (host_uncfg && dev_configured && !bus_reset) |=> !dev_configured);

endmodule

bind usb_ep_hs_ctrl usb_ep_hs_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_reset      (bus_reset),
    .tok_valid      (tok_valid),
    .tok_kind       (tok_kind),
    .tok_ok         (tok_ok),
    .host_sel       (host_sel),
    .host_set_halt  (host_set_halt),
    .host_clr_halt  (host_clr_halt),
    .host_ep_reset  (host_ep_reset),
    .host_stall_cmd (host_stall_cmd),
    .host_cfg       (host_cfg),
    .host_uncfg     (host_uncfg),
    .resp_valid     (resp_valid),
    .resp_code      (resp_code),
    .ep_halted      (ep_halted),
    .ep_toggle      (ep_toggle),
    .dev_configured (dev_configured)
);

// File: tb/usb_ep_hs_ctrl_bench.sv
// Bench for usb_ep_hs_ctrl: behavioural reference model compared on every
// clock, plus directed scenarios for each requirement, then random traffic.
module usb_ep_hs_ctrl_bench;

    localparam int NEP = 4;
    localparam int EW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_reset = 1'b0;
    logic          tok_valid = 1'b0;
    logic [1:0]    tok_kind = 2'd0;
    logic [EW-1:0] tok_ep = '0;
    logic          tok_ok = 1'b0;
    logic [EW-1:0] host_sel = '0;
    logic          host_set_halt = 1'b0;
    logic          host_clr_halt = 1'b0;
    logic          host_ep_reset = 1'b0;
    logic          host_fifo_set = 1'b0;
    logic          host_stall_cmd = 1'b0;
    logic          host_cfg = 1'b0;
    logic          host_uncfg = 1'b0;
    logic           resp_valid;
    logic [1:0]     resp_code;
    logic [NEP-1:0] ep_halted;
    logic [NEP-1:0] ep_toggle;
    logic [NEP-1:0] ep_fifo_en;
    logic           dev_configured;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    int m_halt [NEP];
    int m_tog  [NEP];
    int m_fifo [NEP];
    int m_cmd, m_stk, m_cfg, m_vld, m_code;
    string m_req = "R1";

    always #2.5 clk = ~clk;

    usb_ep_hs_ctrl #(.NUM_EP(NEP)) u_usb_ep_hs_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_ep(tok_ep), .tok_ok(tok_ok),
        .host_sel(host_sel), .host_set_halt(host_set_halt),
        .host_clr_halt(host_clr_halt), .host_ep_reset(host_ep_reset),
        .host_fifo_set(host_fifo_set), .host_stall_cmd(host_stall_cmd),
        .host_cfg(host_cfg), .host_uncfg(host_uncfg),
        .resp_valid(resp_valid), .resp_code(resp_code), .ep_halted(ep_halted),
        .ep_toggle(ep_toggle), .ep_fifo_en(ep_fifo_en),
        .dev_configured(dev_configured)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        int e;
        int s;
        int code;
        if (!rst_n || bus_reset) begin
            for (int i = 0; i < NEP; i++) begin
                m_halt[i] = 0; m_tog[i] = 0; m_fifo[i] = 0;
            end
            m_cmd = 0; m_stk = 0; m_cfg = 0; m_vld = 0; m_code = 0; m_req = "R1";
        end else begin
            code = 0; m_req = "R2";
            e = int'(tok_ep);
            if (tok_valid) begin
                if (!tok_ok || tok_kind == 2'd3) begin
                    code = 0; m_req = "R3";
                end else if (tok_kind == 2'd2) begin
                    code = 1; m_req = "R4";
                    m_tog[e] = 0;
                    if (e == 0) begin m_halt[0] = 0; m_cmd = 0; m_stk = 0; end
                end else if (m_halt[e] != 0 || (e == 0 && (m_cmd != 0 || m_stk != 0))) begin
                    code = 3; m_req = "R6";
                    if (e == 0) m_stk = 1;
                end else if (m_fifo[e] == 0) begin
                    code = 2; m_req = "R7";
                end else begin
                    code = 1; m_req = "R8";
                    m_fifo[e] = 0; m_tog[e] = 1 - m_tog[e];
                end
            end
            s = int'(host_sel);
            if (host_ep_reset) begin m_halt[s] = 0; m_tog[s] = 0; m_fifo[s] = 0; end
            if (host_clr_halt && s == 0) m_halt[0] = 0;
            if (host_set_halt) m_halt[s] = 1;
            if (host_fifo_set) m_fifo[s] = 1;
            if (host_stall_cmd) m_cmd = 1;
            if (host_cfg && m_cfg == 0) m_cfg = 1;
            else if (host_uncfg && m_cfg != 0) m_cfg = 0;
            m_vld = tok_valid ? 1 : 0;
            m_code = code;
        end
        started = 1'b1;
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(resp_valid == m_vld[0], "R2", "resp_valid", int'(resp_valid), m_vld);
            if (m_vld != 0)
                check(int'(resp_code) == m_code, m_req, "resp_code", int'(resp_code), m_code);
            check(dev_configured == m_cfg[0], "R13", "configured", int'(dev_configured), m_cfg);
            for (int i = 0; i < NEP; i++) begin
                check(ep_halted[i] == m_halt[i][0], "R10", $sformatf("halted[%0d]", i),
                      int'(ep_halted[i]), m_halt[i]);
                check(ep_toggle[i] == m_tog[i][0], "R8", $sformatf("toggle[%0d]", i),
                      int'(ep_toggle[i]), m_tog[i]);
                check(ep_fifo_en[i] == m_fifo[i][0], "R11", $sformatf("fifo_en[%0d]", i),
                      int'(ep_fifo_en[i]), m_fifo[i]);
            end
        end
    end

    // Apply the inputs set since the last falling edge for one clock.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        tok_valid = 0; tok_ok = 0; tok_kind = 0; tok_ep = 0;
        host_set_halt = 0; host_clr_halt = 0; host_ep_reset = 0;
        host_fifo_set = 0; host_stall_cmd = 0; host_cfg = 0; host_uncfg = 0;
        bus_reset = 0;
    endtask

    task automatic tok(input int kind, input int ep, input bit ok);
        tok_valid = 1; tok_kind = 2'(kind); tok_ep = EW'(ep); tok_ok = ok;
        cyc();
    endtask

    task automatic hsel(input int ep);
        host_sel = EW'(ep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state.
        check(ep_halted == 0 && ep_toggle == 0 && ep_fifo_en == 0 && !dev_configured
              && !resp_valid, "R1", "reset state", int'(ep_halted), 0);

        // R8: ACK flips toggle, consumes FIFO.
        hsel(1); host_fifo_set = 1; cyc();
        tok(0, 1, 1);
        check(resp_valid && resp_code == 1, "R8", "OUT ep1 ready", int'(resp_code), 1);
        check(ep_toggle[1] == 1 && ep_fifo_en[1] == 0, "R8", "toggle1/fifo1",
              int'({ep_toggle[1], ep_fifo_en[1]}), 2);
        cyc();
        check(!resp_valid, "R2", "resp_valid idle", int'(resp_valid), 0);
        // R7: NAK when FIFO not ready.
        tok(1, 1, 1);
        check(resp_code == 2 && ep_toggle[1] == 1, "R7", "NAK ep1", int'(resp_code), 2);

        // R10, R6: halt ep2, STALL over ready FIFO.
        hsel(2); host_set_halt = 1; cyc();
        check(ep_halted[2] == 1, "R10", "set halt ep2", int'(ep_halted[2]), 1);
        hsel(2); host_fifo_set = 1; cyc();
        tok(1, 2, 1);
        check(resp_code == 3 && ep_fifo_en[2] == 1, "R6", "STALL ep2", int'(resp_code), 3);
        // R12: clear-halt ignored for ep2.
        hsel(2); host_clr_halt = 1; cyc();
        check(ep_halted[2] == 1, "R12", "clr halt ep2 ignored", int'(ep_halted[2]), 1);
        // R11: endpoint reset.
        hsel(2); host_ep_reset = 1; cyc();
        check(ep_halted[2] == 0 && ep_fifo_en[2] == 0 && ep_toggle[2] == 0, "R11",
              "reset ep2", int'({ep_halted[2], ep_fifo_en[2]}), 0);

        // R10, R6: forced stall keeps halt bit, still stalls ep0.
        host_stall_cmd = 1; cyc();
        check(ep_halted[0] == 0, "R10", "stall cmd halt0", int'(ep_halted[0]), 0);
        hsel(0); host_fifo_set = 1; cyc();
        tok(0, 0, 1);
        check(resp_code == 3, "R6", "forced STALL ep0", int'(resp_code), 3);

        // R3: damaged setup and reserved kind get no handshake.
        tok(2, 0, 0);
        check(resp_valid && resp_code == 0, "R3", "bad setup", int'(resp_code), 0);
        tok(3, 0, 1);
        check(resp_valid && resp_code == 0, "R3", "reserved kind", int'(resp_code), 0);

        // R4, R5: setup releases stall, next OUT acknowledged.
        tok(2, 0, 1);
        check(resp_code == 1 && ep_toggle[0] == 0, "R4", "setup ACK", int'(resp_code), 1);
        tok(0, 0, 1);
        check(resp_code == 1 && ep_toggle[0] == 1, "R5", "post-setup ACK", int'(resp_code), 1);

        // R9: STALL persists after halt cleared until setup.
        hsel(0); host_set_halt = 1; cyc();
        hsel(0); host_fifo_set = 1; cyc();
        tok(1, 0, 1);
        check(resp_code == 3, "R9", "halted ep0 STALL", int'(resp_code), 3);
        hsel(0); host_clr_halt = 1; cyc();
        check(ep_halted[0] == 0, "R12", "clr halt ep0", int'(ep_halted[0]), 0);
        tok(1, 0, 1);
        check(resp_code == 3, "R9", "STALL persists", int'(resp_code), 3);
        tok(2, 0, 1);
        check(resp_code == 1 && ep_toggle[0] == 0 && ep_halted[0] == 0, "R5",
              "setup clears ep0", int'(resp_code), 1);
        tok(1, 0, 1);
        check(resp_code == 1, "R9", "ACK after setup", int'(resp_code), 1);

        // R14: host halt in same cycle as ACKed transaction.
        hsel(3); host_fifo_set = 1; cyc();
        hsel(3); host_set_halt = 1; host_fifo_set = 1;
        tok(0, 3, 1);
        check(resp_code == 1 && ep_halted[3] == 1 && ep_toggle[3] == 1 && ep_fifo_en[3] == 1,
              "R14", "same-cycle order", int'({resp_code, ep_halted[3], ep_fifo_en[3]}), 7);

        // R13: configuration transitions.
        host_uncfg = 1; cyc();
        check(!dev_configured, "R13", "uncfg while addressed", int'(dev_configured), 0);
        host_cfg = 1; cyc();
        check(dev_configured, "R13", "cfg", int'(dev_configured), 1);
        host_cfg = 1; cyc();
        check(dev_configured, "R13", "cfg again", int'(dev_configured), 1);
        host_uncfg = 1; cyc();
        check(!dev_configured, "R13", "uncfg", int'(dev_configured), 0);
        host_cfg = 1; cyc();

        // R1: bus reset.
        bus_reset = 1; tok_valid = 1; tok_kind = 0; tok_ok = 1; cyc();
        check(ep_halted == 0 && ep_toggle == 0 && ep_fifo_en == 0 && !dev_configured
              && !resp_valid, "R1", "bus reset", int'(ep_halted), 0);

        // Random traffic, compared every clock by the model.
        for (int n = 0; n < 3000; n++) begin
            tok_valid = ($urandom_range(0, 1) == 1);
            tok_kind = 2'($urandom_range(0, 3));
            tok_ep = EW'($urandom_range(0, NEP - 1));
            tok_ok = ($urandom_range(0, 9) != 0);
            host_sel = EW'($urandom_range(0, NEP - 1));
            host_set_halt = ($urandom_range(0, 9) == 0);
            host_clr_halt = ($urandom_range(0, 7) == 0);
            host_ep_reset = ($urandom_range(0, 11) == 0);
            host_fifo_set = ($urandom_range(0, 2) == 0);
            host_stall_cmd = ($urandom_range(0, 15) == 0);
            host_cfg = ($urandom_range(0, 9) == 0);
            host_uncfg = ($urandom_range(0, 9) == 0);
            bus_reset = ($urandom_range(0, 199) == 0);
            cyc();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule